// File: doc/BRIEF.md
# Run-Time Configurable Sum-of-Products Array

This block is a small programmable logic array whose two planes live in configuration registers instead of being fixed at build time. The AND plane holds one literal mask per product term: every input can be taken in true form, in complemented form, or left out. The OR plane holds, per output, a mask naming which of the shared product terms feed that output. One product term may feed any number of outputs. Evaluation is purely combinational: the outputs follow the inputs within the same cycle, and no evaluation leaves state behind.

Configuration is written one word at a time through a word-wide port. A plane-select bit chooses the plane and an index picks the term or the output. The write happens at a rising clock edge and only while the configuration enable is high. While that enable is high, every output is held at 0, so half-written programs never reach downstream logic. A build parameter selects a fixed-OR variant instead. In that variant, output k ORs its own dedicated group of product terms and the OR plane has no registers at all. The default size of 10 inputs, 50 product terms and 8 outputs is a typical full-size array.

Top module: `cfg_pla`

## Requirements
- R1: Product term j is the AND of the literals set in its AND-plane word. Bit 2i of that word selects input i in true form, and bit 2i+1 selects input i complemented.
- R2: A product term whose AND-plane word is all zero evaluates to 0. A term that selects both forms of one input also evaluates to 0.
- R3: With FIXED_OR=0, output k is the OR of every product term j whose bit j is set in the OR-plane word for output k. A term may be selected by several outputs at once.
- R4: With FIXED_OR=1, output k is the OR of terms k*G through k*G+G-1, where G = N_PT / N_OUT. Writes aimed at the OR plane change no output.
- R5: A configuration word is stored at a rising edge only when cfg_en and cfg_we are both high. cfg_plane=0 selects the AND plane, with cfg_addr giving the term. cfg_plane=1 selects the OR plane, with cfg_addr giving the output. A write with cfg_en low changes nothing.
- R6: While cfg_en is high, dout is all zero, whatever the inputs and the stored program.
- R7: A synchronous active-high reset clears both planes, so that afterwards dout is 0 for every input.
- R8: dout responds to a change of din within the same cycle, with no clock edge in between. With the program unchanged, equal inputs always give equal outputs.
- R9: A write whose cfg_addr is at or above the number of terms (AND plane) or of outputs (OR plane) stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset; clears both planes |
| cfg_en | input | 1 | Configuration window; blanks dout while high |
| cfg_we | input | 1 | Write strobe for one configuration word |
| cfg_plane | input | 1 | 0 = AND plane, 1 = OR plane |
| cfg_addr | input | AW | Term index (AND plane) or output index (OR plane) |
| cfg_data | input | DW | Literal mask or product-term selection mask |
| din | input | N_IN | Array inputs |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
Two behaviours can meet in one cycle: a configuration window is open while the inputs keep moving, and a write arrives that must be refused. The bench holds cfg_en high and sweeps every input value, expecting all-zero outputs. It then closes the window and checks that the earlier program still evaluates exactly as before. It also fires strobes with the enable low, and strobes with out-of-range indices, between full sweeps. Each of these is judged against a bench-side model of the literal and selection masks over all input combinations.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Plane selector carried on the configuration port.
    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    // Control bundle for one configuration cycle.
    typedef struct packed {
        logic   active;
        logic   write;
        plane_e plane;
    } cfg_ctl_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned index_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN = 10,
    parameter int N_PT = 50,
    parameter int AW   = 6,
    parameter int DW   = 50
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [N_IN-1:0] din,
    output logic [N_PT-1:0] terms
);
    localparam int LW = 2 * N_IN;

    // Interleaved literals: even bit true form, odd bit complement.
    logic [LW-1:0] lit;
    logic          unused_data;

    assign unused_data = ^wr_data;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = din[i];
        assign lit[2*i+1] = ~din[i];
    end

    for (genvar j = 0; j < N_PT; j++) begin : g_term
        logic [LW-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
            end else if (wr_en && wr_idx == AW'(j)) begin
                mask_q <= wr_data[LW-1:0];
            end
        end

        // A term with no connected literal is treated as unused.
        assign terms[j] = (|mask_q) && (&(lit | ~mask_q));
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT     = 50,
    parameter int N_OUT    = 8,
    parameter int AW       = 6,
    parameter int DW       = 50,
    parameter bit FIXED_OR = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [N_PT-1:0]  terms,
    output logic [N_OUT-1:0] sums
);
    localparam int GROUP = N_PT / N_OUT;

    if (FIXED_OR) begin : g_fixed
        logic unused_cfg;
        assign unused_cfg = ^{clk, rst, wr_en, wr_idx, wr_data};

        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            assign sums[k] = |terms[k*GROUP +: GROUP];
        end
    end else begin : g_prog
        logic unused_data;
        assign unused_data = ^wr_data;

        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            logic [N_PT-1:0] sel_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q <= '0;
                end else if (wr_en && wr_idx == AW'(k)) begin
                    sel_q <= wr_data[N_PT-1:0];
                end
            end

            assign sums[k] = |(terms & sel_q);
        end
    end

endmodule

// File: rtl/cfg_pla.sv
module cfg_pla
    import pla_pkg::*;
#(
    parameter int N_IN     = 10,
    parameter int N_PT     = 50,
    parameter int N_OUT    = 8,
    parameter bit FIXED_OR = 1'b0,
    localparam int AW      = index_bits(imax(N_PT, N_OUT)),
    localparam int DW      = imax(2 * N_IN, N_PT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic             cfg_plane,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);
    cfg_ctl_t        ctl;
    logic            and_wr;
    logic            or_wr;
    logic [N_PT-1:0] terms;
    logic [N_OUT-1:0] sums;

    assign ctl = '{active: cfg_en, write: cfg_we, plane: plane_e'(cfg_plane)};

    assign and_wr = ctl.active && ctl.write && (ctl.plane == PLANE_AND)
                    && ({1'b0, cfg_addr} < (AW+1)'(N_PT));
    assign or_wr  = ctl.active && ctl.write && (ctl.plane == PLANE_OR)
                    && ({1'b0, cfg_addr} < (AW+1)'(N_OUT));

    pla_and_plane #(
        .N_IN (N_IN),
        .N_PT (N_PT),
        .AW   (AW),
        .DW   (DW)
    ) u_and (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (and_wr),
        .wr_idx  (cfg_addr),
        .wr_data (cfg_data),
        .din     (din),
        .terms   (terms)
    );

    pla_or_plane #(
        .N_PT     (N_PT),
        .N_OUT    (N_OUT),
        .AW       (AW),
        .DW       (DW),
        .FIXED_OR (FIXED_OR)
    ) u_or (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (or_wr),
        .wr_idx  (cfg_addr),
        .wr_data (cfg_data),
        .terms   (terms),
        .sums    (sums)
    );

    // Blank the array while the program may be half written.
    assign dout = ctl.active ? '0 : sums;

endmodule

// File: rtl/cfg_pla_chk.sv
module cfg_pla_chk #(
    parameter int N_IN  = 10,
    parameter int N_PT  = 50,
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic [N_IN-1:0]  din,
    input logic [N_PT-1:0]  terms,
    input logic [N_OUT-1:0] dout
);
    // R6: configuration window blanks every output.
    assert_cfg_blank_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (dout == '0));

    // R7: the cycle after reset, nothing is programmed.
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R8 and R5: with the window closed, equal inputs give equal outputs.
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !$past(cfg_en) && !$past(rst) && $stable(din)) |-> $stable(dout));

    // R3: an asserted output needs at least one live product term.
    assert_out_term_R3: assert property (@(posedge clk) disable iff (rst)
        (dout != '0) |-> (terms != '0));

endmodule

bind cfg_pla cfg_pla_chk #(
    .N_IN  (N_IN),
    .N_PT  (N_PT),
    .N_OUT (N_OUT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .din    (din),
    .terms  (terms),
    .dout   (dout)
);

// File: tb/cfg_pla_tb.sv
module cfg_pla_tb;

    // Programmable instance: 4 inputs, 6 terms, 3 outputs (addr 3 bits, data 8 bits)
    localparam int AI = 4, AT = 6, AO = 3;
    // Fixed-OR instance: 3 inputs, 4 terms, 2 outputs, group of 2 (addr 2, data 6)
    localparam int BI = 3, BT = 4, BO = 2, BG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       en_a = 0, we_a = 0, pl_a = 0;
    logic [2:0] addr_a = '0;
    logic [7:0] data_a = '0;
    logic [3:0] din_a = '0;
    logic [2:0] dout_a;

    logic       en_b = 0, we_b = 0, pl_b = 0;
    logic [1:0] addr_b = '0;
    logic [5:0] data_b = '0;
    logic [2:0] din_b = '0;
    logic [1:0] dout_b;

    cfg_pla #(.N_IN(AI), .N_PT(AT), .N_OUT(AO), .FIXED_OR(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(en_a), .cfg_we(we_a), .cfg_plane(pl_a),
        .cfg_addr(addr_a), .cfg_data(data_a), .din(din_a), .dout(dout_a));

    cfg_pla #(.N_IN(BI), .N_PT(BT), .N_OUT(BO), .FIXED_OR(1'b1)) u_dut_pal (
        .clk(clk), .rst(rst), .cfg_en(en_b), .cfg_we(we_b), .cfg_plane(pl_b),
        .cfg_addr(addr_b), .cfg_data(data_b), .din(din_b), .dout(dout_b));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] and_a [AT];
    logic [5:0] or_a  [AO];
    logic [5:0] and_b [BT];

    task automatic check(input string req, input int v, input logic [7:0] got,
                         input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s din=%0h actual=%0h expected=%0h", req, v, got, exp);
        end
    endtask

    function automatic logic term_a(input int j, input logic [3:0] x);
        logic [7:0] m = and_a[j];
        if (m == '0) return 1'b0;
        for (int i = 0; i < AI; i++) begin
            if (m[2*i] && !x[i]) return 1'b0;
            if (m[2*i+1] && x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [2:0] model_a(input logic [3:0] x);
        logic [2:0] r = '0;
        for (int k = 0; k < AO; k++)
            for (int j = 0; j < AT; j++)
                if (or_a[k][j] && term_a(j, x)) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic term_b(input int j, input logic [2:0] x);
        logic [5:0] m = and_b[j];
        if (m == '0) return 1'b0;
        for (int i = 0; i < BI; i++) begin
            if (m[2*i] && !x[i]) return 1'b0;
            if (m[2*i+1] && x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [1:0] model_b(input logic [2:0] x);
        logic [1:0] r = '0;
        for (int k = 0; k < BO; k++)
            for (int g = 0; g < BG; g++)
                if (term_b(k*BG + g, x)) r[k] = 1'b1;
        return r;
    endfunction

    task automatic clear_models();
        for (int j = 0; j < AT; j++) and_a[j] = '0;
        for (int k = 0; k < AO; k++) or_a[k] = '0;
        for (int j = 0; j < BT; j++) and_b[j] = '0;
    endtask

    // One write cycle; the mirror follows R5 and R9.
    task automatic wr_a(input logic plane, input logic [2:0] addr,
                        input logic [7:0] data, input logic en);
        @(negedge clk);
        en_a = en; we_a = 1'b1; pl_a = plane; addr_a = addr; data_a = data;
        @(negedge clk);
        we_a = 1'b0; en_a = 1'b0;
        if (en && !plane && addr < AT) and_a[addr] = data;
        if (en && plane && addr < AO) or_a[addr] = data[5:0];
    endtask

    task automatic wr_b(input logic plane, input logic [1:0] addr, input logic [5:0] data);
        @(negedge clk);
        en_b = 1'b1; we_b = 1'b1; pl_b = plane; addr_b = addr; data_b = data;
        @(negedge clk);
        we_b = 1'b0; en_b = 1'b0;
        if (!plane) and_b[addr] = data;
    endtask

    // Inputs change after a falling edge and are sampled 1 ns later (R8).
    task automatic sweep_a(input string req);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            din_a = 4'(v);
            #1 check(req, v, {5'd0, dout_a}, {5'd0, model_a(4'(v))});
        end
    endtask

    task automatic sweep_b(input string req);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            din_b = 3'(v);
            #1 check(req, v, {6'd0, dout_b}, {6'd0, model_b(3'(v))});
        end
    endtask

    initial begin
        clear_models();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R7: reset leaves both planes empty
        sweep_a("R7 reset");
        sweep_b("R7 reset");

        // R1 R3: F1 = A.B' + A.C, F2 = A.C + B.C with A.C shared (A=din0,B=din1,C=din2)
        wr_a(1'b0, 3'd0, 8'b0000_1001, 1'b1);
        wr_a(1'b0, 3'd1, 8'b0001_0001, 1'b1);
        wr_a(1'b0, 3'd2, 8'b0001_0100, 1'b1);
        wr_a(1'b1, 3'd0, 8'b0000_0011, 1'b1);
        wr_a(1'b1, 3'd1, 8'b0000_0110, 1'b1);
        for (int v = 0; v < 16; v++) begin
            logic a, b, c;
            a = v[0]; b = v[1]; c = v[2];
            @(negedge clk);
            din_a = 4'(v);
            #1 check("R1 R3 shared term", v, {5'd0, dout_a},
                     {6'd0, (a & c) | (b & c), (a & ~b) | (a & c)});
        end

        // R6: window open, outputs blank for every input
        @(negedge clk) en_a = 1'b1;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            din_a = 4'(v);
            #1 check("R6 blank", v, {5'd0, dout_a}, 8'd0);
        end
        @(negedge clk) en_a = 1'b0;
        sweep_a("R6 program kept");

        // R5: strobes with the window closed store nothing
        wr_a(1'b0, 3'd1, 8'h00, 1'b0);
        wr_a(1'b1, 3'd0, 8'h3f, 1'b0);
        sweep_a("R5 write ignored");

        // R9: indices past the end store nothing
        wr_a(1'b0, 3'd6, 8'hff, 1'b1);
        wr_a(1'b0, 3'd7, 8'h01, 1'b1);
        wr_a(1'b1, 3'd3, 8'h3f, 1'b1);
        wr_a(1'b1, 3'd7, 8'h3f, 1'b1);
        sweep_a("R9 out of range");

        // R2: empty term and contradictory term feed output 2
        wr_a(1'b0, 3'd3, 8'h00, 1'b1);
        wr_a(1'b0, 3'd4, 8'b0000_0011, 1'b1);
        wr_a(1'b1, 3'd2, 8'b0001_1000, 1'b1);
        sweep_a("R2 dead terms");

        // R1 R3: random programs, all input combinations
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < AT; j++)
                wr_a(1'b0, 3'(j), (j == r) ? 8'h00 : 8'($urandom & $urandom), 1'b1);
            for (int k = 0; k < AO; k++)
                wr_a(1'b1, 3'(k), 8'($urandom & 32'h3f), 1'b1);
            sweep_a("R1 R3 random");
        end

        // R4: fixed groups, OR-plane writes change nothing
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < BT; j++)
                wr_b(1'b0, 2'(j), 6'($urandom & $urandom));
            wr_b(1'b1, 2'd0, 6'h00);
            wr_b(1'b1, 2'd1, 6'h3f);
            sweep_b("R4 fixed OR");
        end

        // R8: two input changes within one low clock phase
        @(negedge clk);
        din_a = 4'h5;
        #1 check("R8 comb", 5, {5'd0, dout_a}, {5'd0, model_a(4'h5)});
        din_a = 4'hA;
        #1 check("R8 comb", 10, {5'd0, dout_a}, {5'd0, model_a(4'hA)});

        // R7: reset in mid-run clears a live program
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        clear_models();
        sweep_a("R7 mid reset");
        sweep_b("R7 mid reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule